// File: doc/BRIEF.md
# Address Pointer Arithmetic Unit

This block carries out the pointer updates of a small 16-bit address generation unit. It holds six 16-bit registers: four general pointers P0 to P3, a stack pointer and an offset register. A caller presents an operation code with a pointer select and an immediate word. The unit then rewrites one register with the result of an increment, a decrement, an add of the offset register, a short unsigned add that is fixed to P2, a short unsigned subtract that is fixed to the stack pointer, a long signed add, or a test that is followed by a decrement.

Each operation is accepted only while `busy` is low. The one-word forms occupy two cycles and the long form occupies four. `done` pulses for one clock at the moment the result is written back. A load port and a combinational read port give direct access to the register file while the unit is idle.

Top module: `agu_ptr_unit`

## Requirements
- R1: After reset `busy`, `done`, `flag_z` and `flag_n` are 0 and every register reads 0x0000.
- R2: Op 0 adds one to the pointer chosen by `reg_sel` and op 1 subtracts one from it, both modulo 2^16.
- R3: Op 2 adds the offset register (register index 5) to the chosen pointer, modulo 2^16.
- R4: Op 3 adds `imm[5:0]`, zero-extended, to P2 (index 2). `reg_sel` and `imm[15:6]` have no effect on it.
- R5: Op 4 subtracts `imm[5:0]`, zero-extended, from the stack pointer (index 4), modulo 2^16.
- R6: Op 5 adds the full 16-bit `imm`, read as two's complement, to the chosen pointer.
- R7: Op 6 sets `flag_z` when the chosen pointer was 0 and sets `flag_n` to its bit 15, both taken before the update, and then writes the pointer minus one. No other op changes the flags.
- R8: An op accepted at clock edge k writes back and raises `done` at edge k+1 for ops 0 to 4 and 6, and at edge k+3 for op 5. `busy` is high from edge k until that write-back.
- R9: `start` has no effect while `busy` is high, and op code 7 is never accepted.
- R10: Register indices are 0 to 3 for the pointers, 4 for the stack pointer and 5 for the offset register. `load_en` writes `load_data` into register `load_sel` only while `busy` is low. Indices 6 and 7 are not written and read as 0. `rd_data` shows register `rd_sel` combinationally.
- R11: `done` is high for exactly one cycle per operation, and a new op may be started in the cycle in which `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to begin an operation |
| op_code | input | 3 | Operation selector, values 0 to 7 |
| reg_sel | input | 2 | Pointer select P0 to P3 |
| imm | input | 16 | Immediate operand |
| load_en | input | 1 | Register file load strobe |
| load_sel | input | 3 | Register index to load |
| load_data | input | 16 | Value to load |
| rd_sel | input | 3 | Register index to read |
| rd_data | output | 16 | Selected register value |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle write-back pulse |
| flag_z | output | 1 | Zero flag from the last test-and-decrement |
| flag_n | output | 1 | Sign flag from the last test-and-decrement |

## Verification
Inputs change on falling edges and outputs are read on falling edges. If `start` is driven before edge k, `done` is first seen on the second falling edge after that drive for a one-word op and on the fourth for the long op. The bench counts falling edges until `done` appears and compares that count with the expected cycle count. The written register and the flags are read on that same falling edge, because they update at the same edge as `done`. Checks that something is ignored read the register file back after the operation that could have disturbed it has finished.

// File: rtl/agu_pkg.sv
package agu_pkg;
  typedef enum logic [2:0] {
    OP_INC   = 3'd0,
    OP_DEC   = 3'd1,
    OP_ADDN  = 3'd2,
    OP_ADDP2 = 3'd3,
    OP_SUBSP = 3'd4,
    OP_ADDL  = 3'd5,
    OP_TSTD  = 3'd6,
    OP_RSVD  = 3'd7
  } agu_op_e;

  localparam int unsigned IDX_W  = 3;
  localparam int unsigned NUM_RG = 6;
  localparam logic [IDX_W-1:0] IDX_P2  = 3'd2;
  localparam logic [IDX_W-1:0] IDX_SP  = 3'd4;
  localparam logic [IDX_W-1:0] IDX_OFS = 3'd5;
endpackage

// File: rtl/agu_regfile.sv
module agu_regfile
  import agu_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_en,
  input  logic [IDX_W-1:0] ld_idx,
  input  logic [DW-1:0]    ld_data,
  input  logic             wb_en,
  input  logic [IDX_W-1:0] wb_idx,
  input  logic [DW-1:0]    wb_data,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [DW-1:0]    rd_data,
  input  logic [IDX_W-1:0] src_idx,
  output logic [DW-1:0]    src_data,
  output logic [DW-1:0]    ofs_data
);
  logic [DW-1:0] rg_q [NUM_RG];

  for (genvar g = 0; g < NUM_RG; g++) begin : g_rg
    logic          we;
    logic [DW-1:0] d;
    always_comb begin
      we = 1'b0;
      d  = rg_q[g];
      if (wb_en && (wb_idx == IDX_W'(g))) begin
        we = 1'b1;
        d  = wb_data;
      end else if (ld_en && (ld_idx == IDX_W'(g))) begin
        we = 1'b1;
        d  = ld_data;
      end
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  rg_q[g] <= '0;
      else if (we) rg_q[g] <= d;
    end
  end

  always_comb begin
    rd_data  = '0;
    src_data = '0;
    for (int i = 0; i < NUM_RG; i++) begin
      if (rd_idx == IDX_W'(i))  rd_data  = rg_q[i];
      if (src_idx == IDX_W'(i)) src_data = rg_q[i];
    end
  end

  assign ofs_data = rg_q[IDX_OFS];

  // R10
  ld_wb_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ld_en && wb_en));
endmodule

// File: rtl/agu_seq.sv
module agu_seq
  import agu_pkg::*;
#(
  parameter int unsigned CYC_SHORT = 2,
  parameter int unsigned CYC_LONG  = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [2:0] op,
  output logic       accept,
  output logic       busy,
  output logic       wb_fire,
  output logic       done
);
  localparam int unsigned CW = $clog2(CYC_LONG + 1);

  agu_op_e       op_e;
  logic          busy_q, busy_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          done_q;

  assign op_e    = agu_op_e'(op);
  assign accept  = start && !busy_q && (op_e != OP_RSVD);
  assign wb_fire = busy_q && (cnt_q == CW'(1));

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    if (accept) begin
      busy_d = 1'b1;
      cnt_d  = (op_e == OP_ADDL) ? CW'(CYC_LONG - 1) : CW'(CYC_SHORT - 1);
    end else if (busy_q) begin
      if (wb_fire) busy_d = 1'b0;
      else         cnt_d  = cnt_q - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      done_q <= wb_fire;
    end
  end

  assign busy = busy_q;
  assign done = done_q;

  // R8
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy);
  // R8
  busy_end_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  // R11
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R9
  rsvd_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && op_e == OP_RSVD) |=> !busy);
endmodule

// File: rtl/agu_alu.sv
module agu_alu
  import agu_pkg::*;
#(
  parameter int unsigned DW = 16,
  parameter int unsigned SW = 6
) (
  input  logic [2:0]       op,
  input  logic [1:0]       psel,
  input  logic [DW-1:0]    imm,
  input  logic [DW-1:0]    src,
  input  logic [DW-1:0]    ofs,
  output logic [IDX_W-1:0] dest,
  output logic [DW-1:0]    result,
  output logic             z_new,
  output logic             n_new
);
  agu_op_e       op_e;
  logic [DW-1:0] short_imm;

  assign op_e      = agu_op_e'(op);
  assign short_imm = {{(DW-SW){1'b0}}, imm[SW-1:0]};

  always_comb begin
    case (op_e)
      OP_ADDP2: dest = IDX_P2;
      OP_SUBSP: dest = IDX_SP;
      default:  dest = {1'b0, psel};
    endcase
  end

  always_comb begin
    case (op_e)
      OP_INC:   result = src + DW'(1);
      OP_DEC:   result = src - DW'(1);
      OP_ADDN:  result = src + ofs;
      OP_ADDP2: result = src + short_imm;
      OP_SUBSP: result = src - short_imm;
      OP_ADDL:  result = src + imm;
      OP_TSTD:  result = src - DW'(1);
      default:  result = src;
    endcase
  end

  assign z_new = (src == '0);
  assign n_new = src[DW-1];
endmodule

// File: rtl/agu_ptr_unit.sv
module agu_ptr_unit
  import agu_pkg::*;
#(
  parameter int unsigned DW        = 16,
  parameter int unsigned SW        = 6,
  parameter int unsigned CYC_SHORT = 2,
  parameter int unsigned CYC_LONG  = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [2:0]    op_code,
  input  logic [1:0]    reg_sel,
  input  logic [DW-1:0] imm,
  input  logic          load_en,
  input  logic [2:0]    load_sel,
  input  logic [DW-1:0] load_data,
  input  logic [2:0]    rd_sel,
  output logic [DW-1:0] rd_data,
  output logic          busy,
  output logic          done,
  output logic          flag_z,
  output logic          flag_n
);
  logic rs_meta_q, rs_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta_q <= 1'b0;
      rs_sync_q <= 1'b0;
    end else begin
      rs_meta_q <= 1'b1;
      rs_sync_q <= rs_meta_q;
    end
  end

  logic          accept, wb_fire, busy_i;
  logic [2:0]    op_q;
  logic [1:0]    psel_q;
  logic [DW-1:0] imm_q;
  logic [IDX_W-1:0] dest;
  logic [DW-1:0] src, ofs, result;
  logic          z_new, n_new;
  logic          fz_q, fn_q, fz_d, fn_d;

  agu_seq #(.CYC_SHORT(CYC_SHORT), .CYC_LONG(CYC_LONG)) u_seq (
    .clk(clk), .rst_n(rs_sync_q), .start(start), .op(op_code),
    .accept(accept), .busy(busy_i), .wb_fire(wb_fire), .done(done)
  );

  always_ff @(posedge clk or negedge rs_sync_q) begin
    if (!rs_sync_q) begin
      op_q   <= 3'd0;
      psel_q <= 2'd0;
      imm_q  <= '0;
    end else if (accept) begin
      op_q   <= op_code;
      psel_q <= reg_sel;
      imm_q  <= imm;
    end
  end

  agu_alu #(.DW(DW), .SW(SW)) u_alu (
    .op(op_q), .psel(psel_q), .imm(imm_q), .src(src), .ofs(ofs),
    .dest(dest), .result(result), .z_new(z_new), .n_new(n_new)
  );

  agu_regfile #(.DW(DW)) u_rf (
    .clk(clk), .rst_n(rs_sync_q),
    .ld_en(load_en && !busy_i), .ld_idx(load_sel), .ld_data(load_data),
    .wb_en(wb_fire), .wb_idx(dest), .wb_data(result),
    .rd_idx(rd_sel), .rd_data(rd_data),
    .src_idx(dest), .src_data(src), .ofs_data(ofs)
  );

  always_comb begin
    fz_d = fz_q;
    fn_d = fn_q;
    if (wb_fire && (agu_op_e'(op_q) == OP_TSTD)) begin
      fz_d = z_new;
      fn_d = n_new;
    end
  end

  always_ff @(posedge clk or negedge rs_sync_q) begin
    if (!rs_sync_q) begin
      fz_q <= 1'b0;
      fn_q <= 1'b0;
    end else begin
      fz_q <= fz_d;
      fn_q <= fn_d;
    end
  end

  assign busy   = busy_i;
  assign flag_z = fz_q;
  assign flag_n = fn_q;

  // R7
  flags_hold_chk: assert property (@(posedge clk) disable iff (!rs_sync_q)
    !(wb_fire && agu_op_e'(op_q) == OP_TSTD) |=> $stable({flag_z, flag_n}));
  // R8
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rs_sync_q)
    (busy && !done && !wb_fire) |=> busy);
endmodule

// File: tb/agu_ptr_unit_test.sv
`timescale 1ns/1ps
module agu_ptr_unit_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [2:0]  op_code;
  logic [1:0]  reg_sel;
  logic [15:0] imm;
  logic        load_en;
  logic [2:0]  load_sel;
  logic [15:0] load_data;
  logic [2:0]  rd_sel;
  logic [15:0] rd_data;
  logic        busy, done, flag_z, flag_n;

  int n_chk = 0;
  int n_err = 0;

  always #2.5 clk = ~clk;

  agu_ptr_unit uut (
    .clk(clk), .rst_n(rst_n), .start(start), .op_code(op_code),
    .reg_sel(reg_sel), .imm(imm), .load_en(load_en), .load_sel(load_sel),
    .load_data(load_data), .rd_sel(rd_sel), .rd_data(rd_data),
    .busy(busy), .done(done), .flag_z(flag_z), .flag_n(flag_n)
  );

  typedef struct packed {
    logic [2:0]  op;
    logic [1:0]  rs;
    logic [15:0] im;
    logic [15:0] init;
    logic [15:0] nval;
    logic [15:0] exp;
    logic        fz;
    logic        fn;
    logic [2:0]  cyc;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VEC [NV] = '{
    '{3'd0, 2'd0, 16'h0000, 16'h1234, 16'h0000, 16'h1235, 1'b0, 1'b0, 3'd2},
    '{3'd0, 2'd1, 16'h0000, 16'hFFFF, 16'h0000, 16'h0000, 1'b0, 1'b0, 3'd2},
    '{3'd1, 2'd3, 16'h0000, 16'h0000, 16'h0000, 16'hFFFF, 1'b0, 1'b0, 3'd2},
    '{3'd2, 2'd2, 16'h0000, 16'h1000, 16'h0F00, 16'h1F00, 1'b0, 1'b0, 3'd2},
    '{3'd2, 2'd1, 16'h0000, 16'hF000, 16'h2000, 16'h1000, 1'b0, 1'b0, 3'd2},
    '{3'd3, 2'd0, 16'hFFC5, 16'h0100, 16'h0000, 16'h0105, 1'b0, 1'b0, 3'd2},
    '{3'd3, 2'd3, 16'h003F, 16'hFFF0, 16'h0000, 16'h002F, 1'b0, 1'b0, 3'd2},
    '{3'd4, 2'd0, 16'h0010, 16'h0100, 16'h0000, 16'h00F0, 1'b0, 1'b0, 3'd2},
    '{3'd4, 2'd2, 16'h0FFF, 16'h0020, 16'h0000, 16'hFFE1, 1'b0, 1'b0, 3'd2},
    '{3'd5, 2'd1, 16'hFFFE, 16'h0005, 16'h0000, 16'h0003, 1'b0, 1'b0, 3'd4},
    '{3'd5, 2'd0, 16'h7FFF, 16'h8001, 16'h0000, 16'h0000, 1'b0, 1'b0, 3'd4},
    '{3'd6, 2'd2, 16'h0000, 16'h0000, 16'h0000, 16'hFFFF, 1'b1, 1'b0, 3'd2},
    '{3'd6, 2'd3, 16'h0000, 16'h8000, 16'h0000, 16'h7FFF, 1'b0, 1'b1, 3'd2},
    '{3'd0, 2'd0, 16'h0000, 16'h0005, 16'h0000, 16'h0006, 1'b0, 1'b1, 3'd2},
    '{3'd6, 2'd1, 16'h0000, 16'h0001, 16'h0000, 16'h0000, 1'b0, 1'b0, 3'd2},
    '{3'd1, 2'd2, 16'h0000, 16'h0000, 16'h0000, 16'hFFFF, 1'b0, 1'b0, 3'd2}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic load(input logic [2:0] idx, input logic [15:0] val);
    load_en = 1'b1; load_sel = idx; load_data = val;
    @(negedge clk);
    load_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] idx, output logic [15:0] val);
    rd_sel = idx;
    #0.5;
    val = rd_data;
  endtask

  task automatic run_op(input logic [2:0] o, input logic [1:0] r,
                        input logic [15:0] im, output int cyc);
    start = 1'b1; op_code = o; reg_sel = r; imm = im;
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    while (!done && cyc < 20) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    n_err++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [15:0] v;
    int cyc;
    start = 0; op_code = 0; reg_sel = 0; imm = 0;
    load_en = 0; load_sel = 0; load_data = 0; rd_sel = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk("R1 busy", {15'd0, busy}, 16'd0);
    chk("R1 done", {15'd0, done}, 16'd0);
    chk("R1 flags", {14'd0, flag_z, flag_n}, 16'd0);
    for (int i = 0; i < 6; i++) begin
      rd(3'(i), v);
      chk("R1 reg", v, 16'h0000);
    end

    // Vector walk: R2 R3 R4 R5 R6 R7 R8
    for (int k = 0; k < NV; k++) begin
      logic [2:0] tgt;
      tgt = (VEC[k].op == 3'd3) ? 3'd2 : (VEC[k].op == 3'd4) ? 3'd4 : {1'b0, VEC[k].rs};
      @(negedge clk);
      load(tgt, VEC[k].init);
      if (VEC[k].op == 3'd2) load(3'd5, VEC[k].nval);
      run_op(VEC[k].op, VEC[k].rs, VEC[k].im, cyc);
      rd(tgt, v);
      chk($sformatf("R2-6 vec%0d result", k), v, VEC[k].exp);
      chk($sformatf("R7 vec%0d flags", k), {14'd0, flag_z, flag_n}, {14'd0, VEC[k].fz, VEC[k].fn});
      chk($sformatf("R8 vec%0d cycles", k), 16'(cyc), {13'd0, VEC[k].cyc});
      @(negedge clk);
    end

    // R4: reg_sel has no effect on the P2 form
    load(3'd3, 16'h4444);
    load(3'd2, 16'h0010);
    run_op(3'd3, 2'd3, 16'h0001, cyc);
    rd(3'd3, v); chk("R4 other pointer untouched", v, 16'h4444);
    rd(3'd2, v); chk("R4 P2 result", v, 16'h0011);

    // R11: one-cycle done pulse
    @(negedge clk);
    chk("R11 done low after pulse", {15'd0, done}, 16'd0);

    // R9: reserved code not accepted
    start = 1'b1; op_code = 3'd7; reg_sel = 2'd0;
    @(negedge clk);
    start = 1'b0;
    chk("R9 reserved busy", {15'd0, busy}, 16'd0);
    @(negedge clk);
    chk("R9 reserved done", {15'd0, done}, 16'd0);

    // R9 and R10: start and load ignored while busy
    load(3'd0, 16'h0100);
    load(3'd3, 16'h1111);
    load(3'd1, 16'h0000);
    start = 1'b1; op_code = 3'd5; reg_sel = 2'd1; imm = 16'h0010;
    @(negedge clk);
    op_code = 3'd0; reg_sel = 2'd0;
    load_en = 1'b1; load_sel = 3'd3; load_data = 16'hAAAA;
    @(negedge clk);
    start = 1'b0; load_en = 1'b0;
    while (!done) @(negedge clk);
    rd(3'd1, v); chk("R6 long add", v, 16'h0010);
    rd(3'd0, v); chk("R9 start while busy", v, 16'h0100);
    rd(3'd3, v); chk("R10 load while busy", v, 16'h1111);

    // R10: out of range indices
    @(negedge clk);
    load(3'd6, 16'hBEEF);
    rd(3'd6, v); chk("R10 index 6 reads 0", v, 16'h0000);
    rd(3'd7, v); chk("R10 index 7 reads 0", v, 16'h0000);
    rd(3'd5, v); chk("R10 offset reg unchanged by index 6", v, 16'h2000);

    // R11: back-to-back start in the done cycle
    load(3'd0, 16'h0007);
    run_op(3'd0, 2'd0, 16'h0000, cyc);
    run_op(3'd0, 2'd0, 16'h0000, cyc);
    chk("R11 second op cycles", 16'(cyc), 16'd2);
    rd(3'd0, v); chk("R11 back-to-back result", v, 16'h0009);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule